// File: doc/BRIEF.md
# Receive Destination-Address Filter with Compress Indication

This block sits beside a receive MAC and decides, from the 48-bit destination address of each incoming frame, whether the frame is kept or dropped. It compares the address against a 16-entry table of station addresses, combines that result with the broadcast, promiscuous and multicast enables of the receive control logic, and can invert the table result so that a small bridge drops traffic for stations it already knows. It also produces a per-frame compress indication for a management bus, in either a "hit" or a "miss" flavour, which broadcast frames never raise.

A 16-bit configuration word holds the compress modes, the inversion, a hold-timing select and four general-purpose output levels. The word can only be changed while the controller's software-reset command bit is held; a hardware reset clears its control bits. The controller drives a strobe with each destination address and receives the verdict one clock later together with a one-cycle result-valid pulse.

A two-state machine sequences the result: `ST_IDLE` (no verdict presented) moves to `ST_RESULT` when the address strobe is seen; `ST_RESULT` stays in `ST_RESULT` when another strobe arrives in that cycle (back-to-back frames) and returns to `ST_IDLE` otherwise. The result-valid output is high exactly in `ST_RESULT`.

Top module: `rx_addr_filter`

## Requirements
- R1: After hardware reset, configuration bits 11..0 read as 0, result-valid, accept and compress outputs are 0, compress output-enable is 0, and every table entry is empty (no address hits).
- R2: A configuration write changes the stored word only while soft_rst is 1; writes with soft_rst at 0 leave the read-back value unchanged. Bits 11..5 and bit 3 always read as 0; bit 4 (hold select) reads back as written.
- R3: Each cycle with da_valid at 1 produces res_valid high in the next cycle only, carrying the verdict for that address; consecutive strobes give consecutive verdicts.
- R4: With bit 0 (reject-on-hit) at 0, a non-broadcast address that equals a valid table entry is accepted and one that matches no entry is rejected when all three receive enables are 0.
- R5: With bit 0 at 1, a table hit is rejected and a table miss is accepted, unless one of the receive-enable paths accepts the frame.
- R6: A broadcast address (all 48 bits 1) is accepted when brd_en is 1, also when bit 0 is 1 and the address is in the table; with brd_en, bit 0 and the table all not applying it is rejected.
- R7: pro_en at 1 accepts every address; amc_en at 1 accepts a multicast address, identified by bit 40 (least significant bit of the first octet) being 1 while the address is not broadcast.
- R8: With bit 2 at 1 and bit 1 at 0, compress output-enable is 1 and compress is raised with the verdict for a table hit and not for a miss.
- R9: With bit 1 at 1 and bit 2 at 0, compress output-enable is 1 and compress is raised for a table miss and not for a hit.
- R10: Compress is never raised for a broadcast address in either mode.
- R11: With bits 2 and 1 both 0, compress output-enable is 0 and cfg_err is 0; with both 1, output-enable is 0, compress stays 0 and cfg_err is 1.
- R12: Each gpo pin equals configuration bit 12+i, and gpo_oe follows ext_bus_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software-reset command bit; gates configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Table entry index |
| tbl_addr | input | 48 | Address written into the entry |
| tbl_vld | input | 1 | Valid bit written into the entry |
| ext_bus_en | input | 1 | Extended bus mode; enables gpo drivers |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first octet in bits 47..40 |
| brd_en | input | 1 | Accept broadcast frames |
| pro_en | input | 1 | Accept all frames |
| amc_en | input | 1 | Accept multicast frames |
| res_valid | output | 1 | Verdict valid pulse |
| accept | output | 1 | Frame accepted (with res_valid) |
| reject | output | 1 | Frame rejected (with res_valid) |
| cmp_out | output | 1 | Compress indication (with res_valid) |
| cmp_oe | output | 1 | Compress output enable; low means high impedance |
| cfg_err | output | 1 | Both compress modes selected |
| gpo | output | 4 | General-purpose output levels |
| gpo_oe | output | 4 | Per-pin output enable for gpo |

## Verification
The inversion of table hits and the broadcast accept path can both apply to one address in the same cycle: the bench loads the all-ones address into the table, sets reject-on-hit and broadcast enable together, and strobes broadcast. The verdict must be accept (the enable path wins) while compress stays low in hit mode, since the broadcast exclusion overrides the table hit. Back-to-back strobes also check that the machine re-enters `ST_RESULT` with the second verdict and not a stale one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rxf_state_e;

    typedef struct packed {
        logic [3:0] gpo;
        logic       hold_sel;
        logic       cmp_hit;
        logic       cmp_miss;
        logic       rej_hit;
    } rxf_cfg_t;

endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        we,
    input  logic [15:0] wdata,
    output rxf_cfg_t    cfg,
    output logic [15:0] rdata
);

    logic       wr_ok;
    logic [3:0] gpo_q;
    logic [3:0] ctl_q;

    assign wr_ok = we && soft_rst;

    // output levels are not reset: undefined until first written
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            gpo_q <= wdata[15:12];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ok) begin
            ctl_q <= {wdata[4], wdata[2], wdata[1], wdata[0]};
        end
    end

    assign cfg.gpo      = gpo_q;
    assign cfg.hold_sel = ctl_q[3];
    assign cfg.cmp_hit  = ctl_q[2];
    assign cfg.cmp_miss = ctl_q[1];
    assign cfg.rej_hit  = ctl_q[0];

    assign rdata = {gpo_q, 7'b0, ctl_q[3], 1'b0, ctl_q[2:0]};

    // R2: writes outside software reset leave control bits untouched
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !soft_rst) |=> $stable(ctl_q));

    // R2: reserved positions never read back as 1
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[11:5] == 7'b0) && !rdata[3]);

endmodule

// File: rtl/rxf_addr_table.sv
module rxf_addr_table #(
    parameter int ENTRIES = 16,
    parameter int AW      = 48,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_vld,
    input  logic [AW-1:0] key,
    output logic          hit
);

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] vld_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [AW-1:0] addr_q;
        logic          vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                addr_q <= '0;
            end else if (wr_en && (wr_idx == IW'(e))) begin
                vld_q  <= wr_vld;
                addr_q <= wr_addr;
            end
        end

        assign vld_vec[e] = vld_q;
        assign hit_vec[e] = vld_q && (addr_q == key);
    end

    assign hit = |hit_vec;

    // R1: a hit needs at least one occupied entry
    p_hit_needs_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (vld_vec != '0));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 48,
    parameter int NGPO    = 4,
    parameter int MC_BIT  = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       cfg_we,
    input  logic [15:0]                cfg_wdata,
    output logic [15:0]                cfg_rdata,
    input  logic                       tbl_we,
    input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
    input  logic [AW-1:0]              tbl_addr,
    input  logic                       tbl_vld,
    input  logic                       ext_bus_en,
    input  logic                       da_valid,
    input  logic [AW-1:0]              da,
    input  logic                       brd_en,
    input  logic                       pro_en,
    input  logic                       amc_en,
    output logic                       res_valid,
    output logic                       accept,
    output logic                       reject,
    output logic                       cmp_out,
    output logic                       cmp_oe,
    output logic                       cfg_err,
    output logic [NGPO-1:0]            gpo,
    output logic [NGPO-1:0]            gpo_oe
);

    rxf_cfg_t   cfg;
    rxf_state_e state_q, state_d;
    logic       hit;
    logic       is_bc, is_mc, flag_acc, tbl_acc, acc_d, cmp_d, mode_ok;
    logic       acc_q, cmp_q;

    rxf_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .rdata    (cfg_rdata)
    );

    rxf_addr_table #(.ENTRIES(ENTRIES), .AW(AW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_addr (tbl_addr),
        .wr_vld  (tbl_vld),
        .key     (da),
        .hit     (hit)
    );

    // verdict for the address presented this cycle
    always_comb begin
        is_bc    = &da;
        is_mc    = da[MC_BIT] && !is_bc;
        flag_acc = pro_en || (is_bc && brd_en) || (is_mc && amc_en);
        tbl_acc  = cfg.rej_hit ? !hit : hit;
        acc_d    = flag_acc || tbl_acc;
        mode_ok  = cfg.cmp_hit ^ cfg.cmp_miss;
        cmp_d    = mode_ok && !is_bc && (cfg.cmp_hit ? hit : !hit);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = da_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = da_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: capture the verdict with each strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            cmp_q <= 1'b0;
        end else if (da_valid) begin
            acc_q <= acc_d;
            cmp_q <= cmp_d;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
    assign accept    = res_valid && acc_q;
    assign reject    = res_valid && !acc_q;
    assign cmp_oe    = mode_ok;
    assign cmp_out   = res_valid && cmp_q && cmp_oe;
    assign cfg_err   = cfg.cmp_hit && cfg.cmp_miss;
    assign gpo       = cfg.gpo;
    assign gpo_oe    = {NGPO{ext_bus_en}};

    // R3: a strobe is followed by a verdict in the next cycle only
    p_result_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);
    p_result_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);

    // R3: accept and reject are exclusive and only with a verdict
    p_verdict_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, reject}) && ((accept || reject) == res_valid));

    // R10: a broadcast strobe never yields compress
    p_bcast_no_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (&da)) |=> !cmp_out);

    // R11: compress is quiet whenever its driver is off
    p_cmp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_oe |-> !cmp_out);
    p_err_no_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !cmp_oe);

endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [47:0] tbl_addr = '0;
    logic        tbl_vld = 1'b0;
    logic        ext_bus_en = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        brd_en = 1'b0;
    logic        pro_en = 1'b0;
    logic        amc_en = 1'b0;
    logic        res_valid, accept, reject, cmp_out, cmp_oe, cfg_err;
    logic [3:0]  gpo, gpo_oe;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [47:0] A_STN  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] A_MISS = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] A_MC   = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] A_BC   = 48'hFF_FF_FF_FF_FF_FF;

    always #5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_vld(tbl_vld),
        .ext_bus_en(ext_bus_en), .da_valid(da_valid), .da(da),
        .brd_en(brd_en), .pro_en(pro_en), .amc_en(amc_en),
        .res_valid(res_valid), .accept(accept), .reject(reject),
        .cmp_out(cmp_out), .cmp_oe(cmp_oe), .cfg_err(cfg_err),
        .gpo(gpo), .gpo_oe(gpo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sr, input logic [15:0] d);
        @(negedge clk);
        soft_rst = sr; cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic tbl_write(input logic [3:0] i, input logic [47:0] a, input logic v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = i; tbl_addr = a; tbl_vld = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_flags(input logic b, input logic p, input logic m);
        brd_en = b; pro_en = p; amc_en = m;
    endtask

    // strobe one address, then check the verdict in the next cycle
    task automatic frame(input string req, input logic [47:0] a,
                         input logic exp_acc, input logic exp_cmp);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        @(negedge clk);
        da_valid = 1'b0;
        chk(req, {29'b0, res_valid, accept, cmp_out}, {29'b0, 1'b1, exp_acc, exp_cmp});
    endtask

    task automatic t_reset;
        chk("R1 cfg", {20'b0, cfg_rdata[11:0]}, 32'h0);
        chk("R1 outs", {27'b0, res_valid, accept, reject, cmp_out, cmp_oe}, 32'h0);
        frame("R1 empty table", A_STN, 1'b0, 1'b0);
    endtask

    task automatic t_cfg_lock;
        cfg_write(1'b1, 16'h5010);
        chk("R2 write under soft reset", {16'b0, cfg_rdata}, 32'h5010);
        cfg_write(1'b0, 16'hA007);
        chk("R2 write ignored", {16'b0, cfg_rdata}, 32'h5010);
        cfg_write(1'b1, 16'hFFFF);
        chk("R2 reserved zero", {16'b0, cfg_rdata}, 32'hF017);
        chk("R11 both modes", {29'b0, cfg_err, cmp_oe, cmp_out}, 32'h4);
        cfg_write(1'b1, 16'h0000);
        chk("R11 no mode", {30'b0, cfg_err, cmp_oe}, 32'h0);
    endtask

    task automatic t_match;
        tbl_write(4'd3, A_STN, 1'b1);
        tbl_write(4'd15, A_MC, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
        frame("R4 hit accepted", A_STN, 1'b1, 1'b0);
        frame("R4 miss rejected", A_MISS, 1'b0, 1'b0);
        frame("R4 invalid entry misses", A_MC, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        da_valid = 1'b1; da = A_STN;
        @(negedge clk);
        da = A_MISS;
        chk("R3 first verdict", {30'b0, res_valid, accept}, 32'h3);
        @(negedge clk);
        da_valid = 1'b0;
        chk("R3 second verdict", {30'b0, res_valid, accept}, 32'h2);
        @(negedge clk);
        chk("R3 single pulse", {31'b0, res_valid}, 32'h0);
    endtask

    task automatic t_reject_on_hit;
        cfg_write(1'b1, 16'h0001);
        set_flags(1'b0, 1'b0, 1'b0);
        frame("R5 hit rejected", A_STN, 1'b0, 1'b0);
        frame("R5 miss accepted", A_MISS, 1'b1, 1'b0);
        set_flags(1'b0, 1'b1, 1'b0);
        frame("R5 promiscuous not inverted", A_STN, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_broadcast;
        cfg_write(1'b1, 16'h0000);
        set_flags(1'b1, 1'b0, 1'b0);
        frame("R6 broadcast accepted", A_BC, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
        frame("R6 broadcast rejected", A_BC, 1'b0, 1'b0);
    endtask

    task automatic t_flags;
        set_flags(1'b0, 1'b1, 1'b0);
        frame("R7 promiscuous", A_MISS, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b1);
        frame("R7 multicast accepted", A_MC, 1'b1, 1'b0);
        frame("R7 unicast not multicast", A_MISS, 1'b0, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cmp_hit;
        cfg_write(1'b1, 16'h0004);
        chk("R8 oe", {30'b0, cmp_oe, cfg_err}, 32'h2);
        frame("R8 hit compress", A_STN, 1'b1, 1'b1);
        frame("R8 miss no compress", A_MISS, 1'b0, 1'b0);
    endtask

    task automatic t_cmp_miss;
        cfg_write(1'b1, 16'h0002);
        chk("R9 oe", {30'b0, cmp_oe, cfg_err}, 32'h2);
        frame("R9 miss compress", A_MISS, 1'b0, 1'b1);
        frame("R9 hit no compress", A_STN, 1'b1, 1'b0);
        set_flags(1'b1, 1'b0, 1'b0);
        frame("R10 broadcast miss no compress", A_BC, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
    endtask

    // inversion and broadcast path fall on the same address
    task automatic t_overlap;
        tbl_write(4'd7, A_BC, 1'b1);
        cfg_write(1'b1, 16'h0005);
        set_flags(1'b1, 1'b0, 1'b0);
        frame("R6 broadcast hit under inversion", A_BC, 1'b1, 1'b0);
        frame("R10 broadcast hit no compress", A_BC, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
        frame("R5 broadcast hit rejected without enable", A_BC, 1'b0, 1'b0);
        tbl_write(4'd7, A_BC, 1'b0);
    endtask

    task automatic t_gpo;
        cfg_write(1'b1, 16'hA000);
        ext_bus_en = 1'b0;
        @(negedge clk);
        chk("R12 levels off", {24'b0, gpo, gpo_oe}, 32'hA0);
        ext_bus_en = 1'b1;
        @(negedge clk);
        chk("R12 levels on", {24'b0, gpo, gpo_oe}, 32'hAF);
        cfg_write(1'b1, 16'h5000);
        chk("R12 levels swap", {24'b0, gpo, gpo_oe}, 32'h5F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cfg_lock;
        t_match;
        t_back_to_back;
        t_reject_on_hit;
        t_broadcast;
        t_flags;
        t_cmp_hit;
        t_cmp_miss;
        t_overlap;
        t_gpo;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule